// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits in the execute stage of a short in-order pipeline. It picks the operand values for each instruction. Each operand can come from the register-file value that decode delivered, from the result this stage produced one cycle earlier, or from a result that the memory-access stage sends back. It carries out register moves and routes store address and data. All of its outputs are registered, so a result appears one clock after the instruction is presented.

Instructions arrive with `in_valid`. The stage completes in one cycle and never stalls, so it has no ready signal, and upstream may present a new instruction on every cycle. When `in_valid` is low, the stage emits a bubble. Forwarding is resolved separately for the base operand and for the data operand. The newest producer wins: first this stage's own previous result, then the memory-stage bundle, then the decode value.

Instruction fields the block decodes (32-bit word):
- A move has bits 27:26 = 00, bit 25 = 0 and bits 24:21 = 1101. Its destination is in bits 15:12 and its source register is in bits 3:0.
- A store has bits 27:26 = 01 and bit 20 = 0. Its base register is in bits 19:16 and its data register is in bits 15:12.
- Any other word does nothing.

Top module: `exfw_unit`

## Requirements
- R1: While `rst_n` is low and after reset, all outputs are 0. The cleared previous-result state is never forwarded, so the first move after reset takes the decode value even when its source register is 0.
- R2: A valid word that is neither a move nor a store produces `out_valid`=1 with `wr_req`=0 and `mem_we`=0 on the next cycle.
- R3: A valid move produces, on the next cycle, `wr_req`=1, `wr_idx`=bits 15:12, `wr_val`= the resolved source operand, and `mem_we`=0.
- R4: A valid store produces, on the next cycle, `mem_we`=1, `mem_addr`= the resolved base operand, `mem_data`= the resolved data operand, and `wr_req`=0.
- R5: If the registered outputs show `wr_req`=1 and `wr_idx` equals an operand's register, that operand takes `wr_val`. This applies even when the memory stage forwards the same register.
- R6: Otherwise, if `fwd_has`=1 and `fwd_idx` equals the operand's register, the operand takes `fwd_val`.
- R7: With neither match, the base operand takes `in_base` and the data or source operand takes `in_opnd`.
- R8: With `in_valid`=0, the next cycle has `out_valid`=0, `wr_req`=0 and `mem_we`=0. An instruction that follows such a bubble gets no self-forwarding.
- R9: `pc_upd` and `flush` stay 0 for every instruction.
- R10: The base and data operands of a store are resolved independently, each from its own source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_ins | input | 32 | Instruction word |
| in_base | input | DW | Decode value of the base register |
| in_opnd | input | DW | Decode value of the data or source register |
| fwd_has | input | 1 | Memory stage writes a register |
| fwd_idx | input | 4 | Register the memory stage writes |
| fwd_val | input | DW | Value the memory stage writes |
| out_valid | output | 1 | Registered outputs belong to an accepted instruction |
| wr_req | output | 1 | Register write request |
| wr_idx | output | 4 | Register to write |
| wr_val | output | DW | Result value |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | DW | Store address |
| mem_data | output | DW | Store data |
| pc_upd | output | 1 | Program-counter update (always 0 here) |
| flush | output | 1 | Pipeline flush (always 0 here) |

## Verification
Directed sequences cover the cases that separate the sources:
- back-to-back moves with the registers swapped, which shows self-forwarding;
- a move followed by a store of its destination, which shows store-data forwarding;
- a memory-stage match against a stale decode value;
- the same register offered by both sources, which shows priority;
- a store whose base and data come from different sources;
- a bubble between dependent moves.

Random traffic on a small register range then mixes moves, stores, non-ops and bubbles, so matches happen often. Every output is compared with a reference model in the bench.

// File: rtl/exfw_pkg.sv
package exfw_pkg;
  localparam int IW = 32;
  localparam int RW = 4;

  typedef enum logic [1:0] {
    K_NOP = 2'd0,
    K_MOV = 2'd1,
    K_STR = 2'd2
  } kind_e;

  function automatic kind_e classify(input logic [IW-1:0] ins);
    if (ins[27:26] == 2'b00 && !ins[25] && ins[24:21] == 4'b1101) return K_MOV;
    if (ins[27:26] == 2'b01 && !ins[20]) return K_STR;
    return K_NOP;
  endfunction
endpackage

// File: rtl/exfw_decode.sv
module exfw_decode
  import exfw_pkg::*;
(
  input  logic [IW-1:0] ins,
  output kind_e         kind,
  output logic [RW-1:0] base_idx,
  output logic [RW-1:0] data_idx,
  output logic [RW-1:0] dest_idx
);
  always_comb begin
    kind     = classify(ins);
    base_idx = ins[19:16];
    dest_idx = ins[15:12];
    data_idx = (kind == K_STR) ? ins[15:12] : ins[3:0];
  end
endmodule

// File: rtl/exfw_pick.sv
module exfw_pick
  import exfw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [RW-1:0] idx,
  input  logic [DW-1:0] dec_val,
  input  logic          self_has,
  input  logic [RW-1:0] self_idx,
  input  logic [DW-1:0] self_val,
  input  logic          mem_has,
  input  logic [RW-1:0] mem_idx,
  input  logic [DW-1:0] mem_val,
  output logic [DW-1:0] val
);
  always_comb begin
    if (self_has && self_idx == idx)     val = self_val;
    else if (mem_has && mem_idx == idx)  val = mem_val;
    else                                 val = dec_val;
  end
endmodule

// File: rtl/exfw_unit.sv
module exfw_unit
  import exfw_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_ins,
  input  logic [DW-1:0] in_base,
  input  logic [DW-1:0] in_opnd,
  input  logic          fwd_has,
  input  logic [RW-1:0] fwd_idx,
  input  logic [DW-1:0] fwd_val,
  output logic          out_valid,
  output logic          wr_req,
  output logic [RW-1:0] wr_idx,
  output logic [DW-1:0] wr_val,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          pc_upd,
  output logic          flush
);
  localparam int NOPND = 2;

  kind_e         kind;
  logic [RW-1:0] base_idx, data_idx, dest_idx;
  logic [RW-1:0] op_idx [NOPND];
  logic [DW-1:0] op_dec [NOPND];
  logic [DW-1:0] op_val [NOPND];

  exfw_decode u_dec (
    .ins      (in_ins),
    .kind     (kind),
    .base_idx (base_idx),
    .data_idx (data_idx),
    .dest_idx (dest_idx)
  );

  assign op_idx[0] = base_idx;
  assign op_dec[0] = in_base;
  assign op_idx[1] = data_idx;
  assign op_dec[1] = in_opnd;

  for (genvar g = 0; g < NOPND; g++) begin : g_pick
    exfw_pick #(.DW(DW)) u_pick (
      .idx      (op_idx[g]),
      .dec_val  (op_dec[g]),
      .self_has (wr_req),
      .self_idx (wr_idx),
      .self_val (wr_val),
      .mem_has  (fwd_has),
      .mem_idx  (fwd_idx),
      .mem_val  (fwd_val),
      .val      (op_val[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_req    <= 1'b0;
      wr_idx    <= '0;
      wr_val    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_req    <= in_valid && kind == K_MOV;
      mem_we    <= in_valid && kind == K_STR;
      if (in_valid && kind == K_MOV) begin
        wr_idx <= dest_idx;
        wr_val <= op_val[1];
      end
      if (in_valid && kind == K_STR) begin
        mem_addr <= op_val[0];
        mem_data <= op_val[1];
      end
    end
  end

  assign pc_upd = 1'b0;
  assign flush  = 1'b0;
endmodule

// File: rtl/exfw_unit_chk.sv
module exfw_unit_chk
  import exfw_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [IW-1:0] in_ins,
  input logic [DW-1:0] in_base,
  input logic [DW-1:0] in_opnd,
  input logic          fwd_has,
  input logic [RW-1:0] fwd_idx,
  input logic [DW-1:0] fwd_val,
  input logic          out_valid,
  input logic          wr_req,
  input logic [RW-1:0] wr_idx,
  input logic [DW-1:0] wr_val,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_data,
  input logic          pc_upd,
  input logic          flush
);
  logic is_mov, is_str;
  assign is_mov = in_valid && classify(in_ins) == K_MOV;
  assign is_str = in_valid && classify(in_ins) == K_STR;

  a_r3_move_writes: assert property (@(posedge clk) disable iff (!rst_n)
    is_mov |=> wr_req && !mem_we && wr_idx == $past(in_ins[15:12]));

  a_r4_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    is_str |=> mem_we && !wr_req);

  a_r8_bubble_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !wr_req && !mem_we);

  a_r5_self_first: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mov && wr_req && wr_idx == in_ins[3:0]) |=> wr_val == $past(wr_val));

  a_r6_mem_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mov && !(wr_req && wr_idx == in_ins[3:0]) && fwd_has && fwd_idx == in_ins[3:0])
      |=> wr_val == $past(fwd_val));

  a_r9_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !pc_upd && !flush);
endmodule

bind exfw_unit exfw_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/test_exfw_unit.sv
module test_exfw_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [31:0]   in_ins = '0;
  logic [DW-1:0] in_base = '0, in_opnd = '0, fwd_val = '0;
  logic          fwd_has = 1'b0;
  logic [3:0]    fwd_idx = '0;
  logic          out_valid, wr_req, mem_we, pc_upd, flush;
  logic [3:0]    wr_idx;
  logic [DW-1:0] wr_val, mem_addr, mem_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  exfw_unit #(.DW(DW)) i_exfw_unit (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit          m_wr;
  logic [3:0]  m_idx;
  logic [31:0] m_val;

  function automatic logic [31:0] mk_mov(input logic [3:0] d, input logic [3:0] s);
    return {4'hE, 2'b00, 1'b0, 4'b1101, 1'b0, 4'h0, d, 8'h00, s};
  endfunction
  function automatic logic [31:0] mk_str(input logic [3:0] b, input logic [3:0] d);
    return {4'hE, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, b, d, 12'h000};
  endfunction
  function automatic int kind_of(input logic [31:0] w);
    if (w[27:26] == 2'b00 && !w[25] && w[24:21] == 4'b1101) return 1;
    if (w[27:26] == 2'b01 && !w[20]) return 2;
    return 0;
  endfunction
  function automatic logic [31:0] pick(input logic [3:0] r, input logic [31:0] dv,
                                       input bit fh, input logic [3:0] fi,
                                       input logic [31:0] fv);
    if (m_wr && m_idx == r) return m_val;
    if (fh && fi == r) return fv;
    return dv;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] w, input logic [31:0] b,
                      input logic [31:0] o, input bit fh, input logic [3:0] fi,
                      input logic [31:0] fv, input string tag);
    int k;
    logic [31:0] eb, eo;
    in_valid = v; in_ins = w; in_base = b; in_opnd = o;
    fwd_has = fh; fwd_idx = fi; fwd_val = fv;
    k  = v ? kind_of(w) : -1;
    eb = pick(w[19:16], b, fh, fi, fv);
    eo = pick(k == 2 ? w[15:12] : w[3:0], o, fh, fi, fv);
    @(negedge clk);
    chk({tag, " out_valid"}, {31'b0, out_valid}, {31'b0, v});
    chk({tag, " wr_req"}, {31'b0, wr_req}, {31'b0, k == 1});
    chk({tag, " mem_we"}, {31'b0, mem_we}, {31'b0, k == 2});
    chk("R9 pc_upd/flush", {30'b0, pc_upd, flush}, 32'd0);
    if (k == 1) begin
      chk({tag, " wr_idx"}, {28'b0, wr_idx}, {28'b0, w[15:12]});
      chk({tag, " wr_val"}, wr_val, eo);
    end
    if (k == 2) begin
      chk({tag, " mem_addr"}, mem_addr, eb);
      chk({tag, " mem_data"}, mem_data, eo);
    end
    m_wr = (k == 1);
    if (k == 1) begin m_idx = w[15:12]; m_val = eo; end
  endtask

  initial begin
    repeat (CLK_PERIOD * 100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_wr = 0; m_idx = '0; m_val = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {wr_val[3:0], mem_addr[3:0], mem_data[3:0],
        out_valid, wr_req, mem_we, wr_idx}, 32'd0);
    rst_n = 1'b1;
    // R1: source r0 after reset must take decode value
    step(1, mk_mov(4'd1, 4'd0), 32'h0, 32'h1111_2222, 0, 4'd0, 32'h0, "R1 first move");
    // R7: no match
    step(1, mk_mov(4'd7, 4'd6), 32'h0, 32'hCAFE_0007, 0, 4'd0, 32'h0, "R7 decode move");
    // R6: memory stage replaces stale r4
    step(1, mk_mov(4'd5, 4'd4), 32'd42, 32'hDEAD_BEEF, 1, 4'd4, 32'hBABA_FAFA, "R6 mem fwd");
    // R5: store of r5 takes previous move result
    step(1, mk_str(4'd8, 4'd5), 32'd1, 32'h0BAD_0BAD, 0, 4'd0, 32'h0, "R5 store data fwd");
    // R5: swapped moves
    step(1, mk_mov(4'd5, 4'd4), 32'd0, 32'h1234_5678, 0, 4'd0, 32'h0, "R3 move r5<-r4");
    step(1, mk_mov(4'd4, 4'd5), 32'd0, 32'h0BAD_0BAD, 0, 4'd0, 32'h0, "R5 swap move");
    // R5: both sources match r4, self wins
    step(1, mk_mov(4'd2, 4'd4), 32'd0, 32'h0BAD_0BAD, 1, 4'd4, 32'h5555_AAAA, "R5 priority");
    // R10: base from memory stage, data from self (r2)
    step(1, mk_str(4'd9, 4'd2), 32'h0BAD_0000, 32'h0BAD_1111, 1, 4'd9, 32'h0000_0100, "R10 split store");
    // R8: bubble then dependent move gets no self forwarding
    step(1, mk_mov(4'd3, 4'd1), 32'd0, 32'h0000_0033, 0, 4'd0, 32'h0, "R3 move r3");
    step(0, mk_mov(4'd6, 4'd3), 32'd0, 32'h0, 0, 4'd0, 32'h0, "R8 bubble");
    step(1, mk_mov(4'd6, 4'd3), 32'd0, 32'h0000_0666, 0, 4'd0, 32'h0, "R8 after bubble");
    // R2: non-op word
    step(1, 32'hE590_0000, 32'd0, 32'd0, 0, 4'd0, 32'h0, "R2 other word");
    step(1, mk_mov(4'd1, 4'd6), 32'd0, 32'h0BAD_0BAD, 0, 4'd0, 32'h0, "R2 nop breaks self");
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [31:0] w;
      sel = $urandom_range(0, 9);
      if (sel < 4)      w = mk_mov(4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
      else if (sel < 7) w = mk_str(4'($urandom_range(0, 3)), 4'($urandom_range(0, 3)));
      else              w = $urandom;
      step(sel != 9, w, $urandom, $urandom, 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 3)), $urandom,
           sel < 4 ? "R3 rand" : sel < 7 ? "R4 rand" : sel == 9 ? "R8 rand" : "R2 rand");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule